// File: doc/BRIEF.md
# Bang-Bang Loop Filter with Proportional Clear

This block is the digital loop filter of a bang-bang phase-locked loop. Once per reference cycle it receives a one-bit early/late decision from the phase detector. It turns each decision into an unsigned oscillator control code. The code is the sum of an integral accumulator and a proportional term. The integral accumulator moves by the integral step on every decision. The proportional term uses a larger step, set by its own gain input.

After reset the filter starts in a fast settling mode. In this mode the proportional term builds up as a separate signed running value, so same-direction decisions push the oscillator hard. When the detector polarity flips, that running value is zeroed and the integral estimate is left unchanged. The frequency then falls back to the integral estimate at once. After a programmable number of back-to-back polarity flips, the filter treats the phase error as small. It then stays in normal proportional-plus-integral operation, where the proportional term is only the current decision times its step. Both gains come from configuration inputs. Depending on a parameter, each gain is read either as a power-of-two shift or as a small integer multiplier.

Top module: `bbpll_pi_filter`

## Requirements
- R1: After reset the control code equals the CENTER parameter (default 512), the proportional running value is zero, and `fast_mode` is 1.
- R2: Each accepted decision (`dec_valid`=1) changes the integral value by +Ki when `dec_up`=1 and by -Ki when `dec_up`=0. In the default shift variant, Ki = 2^`ki_gain`, and a shift of CODE_W or more gives CODE_MAX. The control code is visible on the clock edge that accepts the decision.
- R3: In fast mode, a decision with the same polarity as the previous decision adds +Kp or -Kp to the proportional running value (Kp = 2^`kp_gain`). The code equals the integral value plus the running value.
- R4: In fast mode, a decision whose polarity is opposite to the previous decision clears the proportional running value to zero. The integral value is still updated as in R2, so the code then equals the integral value alone.
- R5: Fast mode ends on the polarity reversal that makes the count of consecutive reversals reach `rev_goal`. A `rev_goal` of 0 acts as 1. A same-polarity decision sets the count back to zero. Normal mode lasts until the next reset.
- R6: In normal mode, each decision sets the proportional term to exactly +Kp or -Kp for that decision, with no accumulation.
- R7: The integral value is clamped to the range 0 to CODE_MAX (default 1023), and the control code is clamped to the same range. Neither wraps.
- R8: Cycles with `dec_valid`=0 leave the code and the mode unchanged, even if the gain inputs change.
- R9: The first decision after reset is never counted as a polarity reversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | A detector decision is present this cycle |
| dec_up | input | 1 | 1: raise the frequency, 0: lower the frequency |
| kp_gain | input | GAIN_W | Proportional gain (shift or multiplier) |
| ki_gain | input | GAIN_W | Integral gain (shift or multiplier) |
| rev_goal | input | CNT_W | Consecutive reversals needed to leave fast mode |
| ctrl_code | output | CODE_W | Oscillator control code |
| fast_mode | output | 1 | 1 while the fast settling mode is active |

## Verification
A run of same-direction decisions tells the accumulating proportional term apart from an integral-only response. An alternating run shows that a reversal clears only the proportional part and that the reversal count reaches the exit point. Mixed runs, where a same-polarity decision breaks the alternation, show that the count restarts. After the exit, alternating and repeated decisions confirm that the proportional term no longer accumulates. An oversized integral shift drives both clamps, and a second reset with a goal of zero covers the earliest possible exit.

// File: rtl/bbpll_filter_pkg.sv
package bbpll_filter_pkg;

   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_FAST   = 1'b1
   } filt_mode_e;

   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int signed_step(input logic up, input int mag);
      return up ? mag : -mag;
   endfunction

endpackage

// File: rtl/bbpll_gain_step.sv
module bbpll_gain_step #(
   parameter int CODE_W   = 10,
   parameter int GAIN_W   = 4,
   parameter bit USE_MULT = 1'b0
) (
   input  logic [GAIN_W-1:0] gain,
   output logic [CODE_W-1:0] step
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;

   generate
      if (USE_MULT) begin : g_mult
         if (GAIN_W > CODE_W) begin : g_bad
            $error("multiplier gain wider than the code");
         end
         always_comb begin
            step = CODE_W'(gain);
         end
      end else begin : g_shift
         always_comb begin
            int s;
            if (int'(gain) >= CODE_W) s = CODE_MAX;
            else s = 1 << gain;
            step = CODE_W'(s);
         end
      end
   endgenerate

endmodule

// File: rtl/bbpll_polarity_tracker.sv
module bbpll_polarity_tracker
   import bbpll_filter_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic             dec_up,
   input  logic [CNT_W-1:0] rev_goal,
   output logic             reversal,
   output filt_mode_e       mode
);
   logic             have_prev_q;
   logic             prev_up_q;
   logic [CNT_W-1:0] rev_cnt_q;
   logic [CNT_W:0]   rev_cnt_inc;
   logic [CNT_W:0]   goal_eff;

   // R9: no reversal is possible until one decision has been seen
   assign reversal    = dec_valid && have_prev_q && (dec_up != prev_up_q);
   assign rev_cnt_inc = {1'b0, rev_cnt_q} + 1'b1;
   assign goal_eff    = (rev_goal == '0) ? (CNT_W+1)'(1) : {1'b0, rev_goal};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev_q <= 1'b0;
         prev_up_q   <= 1'b0;
         rev_cnt_q   <= '0;
         mode        <= MODE_FAST;
      end else if (dec_valid) begin
         have_prev_q <= 1'b1;
         prev_up_q   <= dec_up;
         if (mode == MODE_FAST) begin
            if (reversal) begin
               if (rev_cnt_inc >= goal_eff) begin
                  mode      <= MODE_NORMAL;
                  rev_cnt_q <= '0;
               end else begin
                  rev_cnt_q <= rev_cnt_inc[CNT_W-1:0];
               end
            end else begin
               rev_cnt_q <= '0;
            end
         end
      end
   end

   // R5: normal mode is permanent until reset
   a_r5_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_NORMAL) |=> (mode == MODE_NORMAL));

   // R9: first decision after reset cannot be a reversal
   a_r9_first_not_rev: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !have_prev_q) |-> !reversal);

endmodule

// File: rtl/bbpll_integral_path.sv
module bbpll_integral_path
   import bbpll_filter_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int CENTER = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_valid,
   input  logic              dec_up,
   input  logic [CODE_W-1:0] ki_step,
   output logic [CODE_W-1:0] integ
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;

   logic [CODE_W-1:0] integ_next;

   always_comb begin
      int v;
      v = int'(integ) + signed_step(dec_up, int'(ki_step));
      integ_next = CODE_W'(clamp_int(v, 0, CODE_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) integ <= CODE_W'(CENTER);
      else if (dec_valid) integ <= integ_next;
   end

   // R2: an up decision never lowers the integral value, a down never raises it
   a_r2_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_up) |=> (integ >= $past(integ)));

   a_r2_direction_dn: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_up) |=> (integ <= $past(integ)));

endmodule

// File: rtl/bbpll_prop_path.sv
module bbpll_prop_path
   import bbpll_filter_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dec_valid,
   input  logic                dec_up,
   input  logic                reversal,
   input  filt_mode_e          mode,
   input  logic [CODE_W-1:0]   kp_step,
   output logic signed [CODE_W+1:0] prop
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;
   localparam int PW       = CODE_W + 2;

   logic signed [PW-1:0] prop_next;

   always_comb begin
      int d;
      d = signed_step(dec_up, int'(kp_step));
      if (mode == MODE_FAST) begin
         if (reversal) prop_next = '0;
         else prop_next = PW'(clamp_int(int'(prop) + d, -CODE_MAX, CODE_MAX));
      end else begin
         prop_next = PW'(d);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prop <= '0;
      else if (dec_valid) prop <= prop_next;
   end

   // R4: a reversal in fast mode leaves no proportional contribution
   a_r4_clear_on_rev: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && reversal && mode == MODE_FAST) |=> (prop == '0));

   // R6: in normal mode the term is a single step of the decision's sign
   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && mode == MODE_NORMAL) |=>
         ((dec_up && prop == $signed({2'b00, $past(kp_step)})) ||
          (!$past(dec_up) && prop == -$signed({2'b00, $past(kp_step)})) ||
          ($past(dec_up) && prop == $signed({2'b00, $past(kp_step)}))));

endmodule

// File: rtl/bbpll_code_combiner.sv
module bbpll_code_combiner
   import bbpll_filter_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input  logic [CODE_W-1:0]        integ,
   input  logic signed [CODE_W+1:0] prop,
   output logic [CODE_W-1:0]        code
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;

   always_comb begin
      int sum;
      sum  = int'(integ) + int'(prop);
      code = CODE_W'(clamp_int(sum, 0, CODE_MAX));
   end

   // R7: full-scale integral with a positive term stays at full scale
   a_r7_top_clamp: assert final ((int'(integ) + int'(prop) < CODE_MAX) ||
                                 (code == CODE_W'(CODE_MAX)));

endmodule

// File: rtl/bbpll_pi_filter.sv
module bbpll_pi_filter
   import bbpll_filter_pkg::*;
#(
   parameter int CODE_W   = 10,
   parameter int GAIN_W   = 4,
   parameter int CNT_W    = 4,
   parameter int CENTER   = 512,
   parameter bit USE_MULT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_valid,
   input  logic              dec_up,
   input  logic [GAIN_W-1:0] kp_gain,
   input  logic [GAIN_W-1:0] ki_gain,
   input  logic [CNT_W-1:0]  rev_goal,
   output logic [CODE_W-1:0] ctrl_code,
   output logic              fast_mode
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;

   generate
      if (CODE_W < 2 || CODE_W > 24) begin : g_bad_w
         $error("CODE_W out of supported range");
      end
      if (CENTER < 0 || CENTER > CODE_MAX) begin : g_bad_c
         $error("CENTER outside the code range");
      end
      if (CNT_W < 1 || GAIN_W < 1) begin : g_bad_cnt
         $error("counter and gain widths must be positive");
      end
   endgenerate

   logic [CODE_W-1:0]        kp_step;
   logic [CODE_W-1:0]        ki_step;
   logic [CODE_W-1:0]        integ;
   logic signed [CODE_W+1:0] prop;
   logic                     reversal;
   filt_mode_e               mode;

   logic [GAIN_W-1:0] gains   [2];
   logic [CODE_W-1:0] steps   [2];

   assign gains[0] = kp_gain;
   assign gains[1] = ki_gain;
   assign kp_step  = steps[0];
   assign ki_step  = steps[1];

   for (genvar g = 0; g < 2; g++) begin : g_step
      bbpll_gain_step #(
         .CODE_W  (CODE_W),
         .GAIN_W  (GAIN_W),
         .USE_MULT(USE_MULT)
      ) i_step (
         .gain(gains[g]),
         .step(steps[g])
      );
   end

   bbpll_polarity_tracker #(.CNT_W(CNT_W)) i_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .dec_valid(dec_valid),
      .dec_up   (dec_up),
      .rev_goal (rev_goal),
      .reversal (reversal),
      .mode     (mode)
   );

   bbpll_integral_path #(.CODE_W(CODE_W), .CENTER(CENTER)) i_integ (
      .clk      (clk),
      .rst_n    (rst_n),
      .dec_valid(dec_valid),
      .dec_up   (dec_up),
      .ki_step  (ki_step),
      .integ    (integ)
   );

   bbpll_prop_path #(.CODE_W(CODE_W)) i_prop (
      .clk      (clk),
      .rst_n    (rst_n),
      .dec_valid(dec_valid),
      .dec_up   (dec_up),
      .reversal (reversal),
      .mode     (mode),
      .kp_step  (kp_step),
      .prop     (prop)
   );

   bbpll_code_combiner #(.CODE_W(CODE_W)) i_comb (
      .integ(integ),
      .prop (prop),
      .code (ctrl_code)
   );

   assign fast_mode = (mode == MODE_FAST);

   // R8: idle cycles change neither the code nor the mode
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> ($stable(ctrl_code) && $stable(fast_mode)));

endmodule

// File: tb/test_bbpll_pi_filter.sv
module test_bbpll_pi_filter;
   localparam int CODE_W   = 10;
   localparam int GAIN_W   = 4;
   localparam int CNT_W    = 4;
   localparam int CENTER   = 512;
   localparam int CODE_MAX = (1 << CODE_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dec_valid = 1'b0;
   logic              dec_up = 1'b0;
   logic [GAIN_W-1:0] kp_gain = 4'd4;
   logic [GAIN_W-1:0] ki_gain = 4'd1;
   logic [CNT_W-1:0]  rev_goal = 4'd3;
   logic [CODE_W-1:0] ctrl_code;
   logic              fast_mode;

   int total = 0;
   int bad   = 0;

   bbpll_pi_filter #(
      .CODE_W(CODE_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W), .CENTER(CENTER)
   ) i_bbpll_pi_filter (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_up(dec_up),
      .kp_gain(kp_gain), .ki_gain(ki_gain), .rev_goal(rev_goal),
      .ctrl_code(ctrl_code), .fast_mode(fast_mode)
   );

   always #5 clk = ~clk;

   // reference model
   int m_i, m_p, m_cnt;
   bit m_fast, m_have, m_prev;

   typedef struct {
      int    code;
      bit    fast;
      string tag;
   } exp_t;
   exp_t sb[$];

   function automatic int clampv(int v, int lo, int hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   function automatic int stepv(logic [GAIN_W-1:0] g);
      return (int'(g) >= CODE_W) ? CODE_MAX : (1 << g);
   endfunction

   function automatic int model_code();
      return clampv(m_i + m_p, 0, CODE_MAX);
   endfunction

   task automatic model_reset();
      m_i = CENTER; m_p = 0; m_cnt = 0;
      m_fast = 1'b1; m_have = 1'b0; m_prev = 1'b0;
   endtask

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: one decision per call, pushes expected result
   task automatic decide(bit up, string tag);
      bit   rev;
      int   kp, ki, goal;
      exp_t e;
      @(negedge clk);
      dec_valid = 1'b1;
      dec_up    = up;
      kp   = stepv(kp_gain);
      ki   = stepv(ki_gain);
      goal = (rev_goal == 0) ? 1 : int'(rev_goal);
      rev  = m_have && (up != m_prev);
      m_i  = clampv(m_i + (up ? ki : -ki), 0, CODE_MAX);
      if (m_fast) begin
         if (rev) begin
            m_p = 0;
            m_cnt++;
            if (m_cnt >= goal) begin m_fast = 1'b0; m_cnt = 0; end
         end else begin
            m_cnt = 0;
            m_p = clampv(m_p + (up ? kp : -kp), -CODE_MAX, CODE_MAX);
         end
      end else begin
         m_p = up ? kp : -kp;
      end
      m_have = 1'b1;
      m_prev = up;
      e.code = model_code();
      e.fast = m_fast;
      e.tag  = tag;
      sb.push_back(e);
   endtask

   task automatic idle(int n, string tag);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         dec_valid = 1'b0;
         if (k == 1) begin kp_gain = 4'd7; ki_gain = 4'd6; end
         if (k > 0) begin
            check({tag, " code"}, int'(ctrl_code), model_code());
            check({tag, " mode"}, int'(fast_mode), int'(m_fast));
         end
      end
   endtask

   // monitor: compare after each accepted decision
   bit vseen = 1'b0;
   always @(posedge clk) vseen <= dec_valid;

   always @(negedge clk) begin
      if (vseen && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check({e.tag, " code"}, int'(ctrl_code), e.code);
         check({e.tag, " mode"}, int'(fast_mode), int'(e.fast));
      end
   end

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      dec_valid = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      check("R1 reset code", int'(ctrl_code), CENTER);
      check("R1 reset mode", int'(fast_mode), 1);
      rst_n = 1'b1;
   endtask

   initial begin
      model_reset();
      do_reset();
      // R9 first decision, R2/R3 same-direction accumulation
      decide(1'b0, "R9 first down");
      for (int k = 0; k < 5; k++) decide(1'b1, "R3 up run");
      decide(1'b1, "R2 up run");
      // R4 reversal clears proportional, count 1
      decide(1'b0, "R4 reversal");
      // R5 same polarity restarts the count
      decide(1'b0, "R5 count restart");
      decide(1'b1, "R4 rev a");
      decide(1'b0, "R5 rev b");
      decide(1'b1, "R5 exit on third");
      // R6 normal mode, no accumulation
      decide(1'b1, "R6 up");
      decide(1'b1, "R6 up again");
      decide(1'b0, "R6 down");
      decide(1'b1, "R6 up after down");
      // R8 idle with gain change
      idle(5, "R8 idle");
      kp_gain = 4'd4; ki_gain = 4'd1;
      // R7 saturation with oversized integral shift
      ki_gain = 4'd15;
      decide(1'b1, "R7 top clamp");
      decide(1'b1, "R7 top hold");
      decide(1'b0, "R7 bottom clamp");
      decide(1'b0, "R7 bottom hold");
      ki_gain = 4'd1;
      decide(1'b1, "R2 after clamp");
      // second reset, goal zero behaves as one
      @(negedge clk);
      dec_valid = 1'b0;
      @(negedge clk);
      rev_goal = 4'd0;
      do_reset();
      decide(1'b1, "R9 first up");
      decide(1'b1, "R3 up");
      decide(1'b0, "R5 goal zero exit");
      decide(1'b0, "R6 down normal");
      @(negedge clk);
      dec_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 queue drained", sb.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule